// File: doc/BRIEF.md
# PLL Mode Register Sequencer

This block is the control and status front end of a frequency synthesiser. Software reaches it through a word-wide register bus. It holds the mode word, the integer multiplier word, a 40-bit fractional word split over two registers, and plain storage for user, configuration and test settings. Behind the registers, small state machines model how the synthesiser responds. A lock detector runs after the core leaves bypass and reset. A vote path raises an active flag, and an offline request is answered with an acknowledge. An update handshake copies the programmed integer and fractional words onto the frequency words that the core actually uses. All analog delays are counted in reference-clock cycles and set by parameters.

A typical power-up writes the multiplier words first. Software then releases bypass, then reset, then enables the output once lock is reported. Power-down works in the opposite order. The block delays the internal drop of reset and bypass until the output has been gated for a drain window. This holds even if software clears all three bits in one write. A frequency change writes the new words and sets the update bit. The words reach the core only when the handshake commits them.

Mode word layout (bit positions are fixed because software decodes them): 0 output enable, 1 bypass release, 2 core reset release (active low), 7 offline request, 13:8 lock count field, 19:14 bias count field, 20 vote enable, 21 vote reset, 22 update, 23 update bypass, 28 offline acknowledge, 29 latch acknowledge, 30 active flag, 31 lock detect. Bits 6:3 and 27:24 are reserved.

State machines and transitions:
- Lock FSM, states LK_IDLE, LK_ACQ and LK_LOCKED:
  - LK_IDLE to LK_ACQ: the core is out of bypass and reset and the settle window has elapsed.
  - LK_ACQ to LK_LOCKED: after LOCK_CYC cycles.
  - Any state to LK_IDLE: the core re-enters bypass or reset.
- Vote FSM, states VT_OFF, VT_RISE, VT_ON and VT_FALL:
  - VT_OFF to VT_RISE: vote enable is set.
  - VT_RISE to VT_ON: after VOTE_CYC cycles.
  - VT_RISE to VT_OFF: vote enable is cleared before VT_ON is reached.
  - VT_ON to VT_FALL: vote enable is cleared.
  - VT_FALL to VT_OFF: after VOTE_CYC cycles.
  - VT_FALL to VT_ON: vote enable is set again.
  - Any state to VT_OFF: vote reset is set.
- Update FSM, states UP_IDLE, UP_WAIT and UP_ACK:
  - UP_IDLE to UP_WAIT: the update bit is set.
  - UP_WAIT to UP_ACK: after ACK_CYC cycles. The words are committed on this transition.
  - UP_WAIT to UP_IDLE: the update bit is cleared first.
  - UP_ACK to UP_IDLE: the update bit reads zero.

Top module: `pll_mode_seq`

## Requirements
- R1: After reset every register reads zero, and `pll_out_en`, `pll_l_word` and `pll_alpha_word` are zero.
- R2: Byte offsets are 0x00 mode, 0x04 integer word (low L_W bits kept), 0x08 fraction low, 0x0C fraction high (low 8 bits kept), 0x10 user, 0x14 user high, 0x18 config, 0x1C test, 0x20 test high, 0x24 status. The lock-count and bias-count fields read back as written. Unmapped or misaligned addresses read zero and ignore writes.
- R3: Mode bits 31:28 and the reserved bits 6:3 and 27:24 ignore writes. The status register ignores writes. It reads {28'b0, lock, active, latch ack, offline ack} in bits 3:0.
- R4: Lock detect (mode bit 31) rises exactly 2+SETTLE_CYC+LOCK_CYC cycles after one write releases bypass and reset together. It rises 2+LOCK_CYC cycles after the reset release when bypass was released earlier than the settle window. It never rises while only bypass is released.
- R5: With the output disabled, clearing the reset bit drops lock detect one cycle after the write.
- R6: Clearing output enable gates `pll_out_en` at once. The core's reset and bypass stay high while output enable is set, and for DRAIN_CYC+1 cycles after it falls. Lock detect therefore falls 2+DRAIN_CYC cycles after one write that clears all three bits.
- R7: After the update bit is written, the latch acknowledge (bit 29) rises ACK_CYC+1 cycles later, in the same cycle that `pll_l_word` and `pll_alpha_word` take the programmed words. With update bypass clear, hardware clears the update bit one cycle later, and the acknowledge falls one cycle after that.
- R8: With update bypass (bit 23) set, the update bit and the acknowledge stay set until software writes the update bit to zero. The acknowledge then falls one cycle after that write.
- R9: Writes to the integer and fraction registers do not change `pll_l_word` or `pll_alpha_word` until an update commits them.
- R10: Setting vote enable (bit 20) raises the active flag 1+VOTE_CYC cycles later, and clearing it drops the flag 1+VOTE_CYC cycles later. Vote reset (bit 21) drops the flag one cycle after it is written.
- R11: The offline acknowledge (bit 28) rises OFFL_CYC cycles after the offline request (bit 7) is set, and falls one cycle after the request is cleared.
- R12: `pll_out_en` is high only while output enable is set and lock detect is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | AW | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pll_out_en | output | 1 | Gated output enable toward the clock network |
| pll_l_word | output | L_W | Committed integer multiplier |
| pll_alpha_word | output | ALPHA_W | Committed fractional multiplier |

## Verification
The properties watch the handshake rules on every cycle:
- the acknowledge never rises sooner than two cycles after the update request;
- the automatic clear follows the acknowledge;
- the acknowledge falls only when the update bit is low;
- lock never rises before the settle window;
- the core's reset never drops while the output was enabled in the two cycles before;
- the active flag and the offline acknowledge only follow their requests.

The exact latencies, the commit of the programmed words, read-only masking, the address map and the power-down ordering can only be shown by the bench's timed register scenarios.

// File: rtl/pll_seq_pkg.sv
`timescale 1ns/1ps
package pll_seq_pkg;
    localparam int MB_OUT    = 0;
    localparam int MB_BYP    = 1;
    localparam int MB_RSTN   = 2;
    localparam int MB_OFFREQ = 7;
    localparam int MB_LCNT   = 8;
    localparam int MB_BCNT   = 14;
    localparam int MB_VOTE   = 20;
    localparam int MB_VRST   = 21;
    localparam int MB_UPD    = 22;
    localparam int MB_UBYP   = 23;

    typedef enum logic [1:0] {LK_IDLE, LK_ACQ, LK_LOCKED} lock_st_e;
    typedef enum logic [1:0] {VT_OFF, VT_RISE, VT_ON, VT_FALL} vote_st_e;
    typedef enum logic [1:0] {UP_IDLE, UP_WAIT, UP_ACK} upd_st_e;
endpackage

// File: rtl/pll_core_gate.sv
`timescale 1ns/1ps
module pll_core_gate #(
    parameter int DRAIN_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic out_bit,
    input  logic byp_bit,
    input  logic rstn_bit,
    output logic core_byp,
    output logic core_rstn
);
    localparam int DW = $clog2(DRAIN_CYC + 1);

    logic          out_prev;
    logic [DW-1:0] drain_q;
    logic          hold;

    assign hold = out_bit | out_prev | (drain_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_prev  <= 1'b0;
            drain_q   <= '0;
            core_byp  <= 1'b0;
            core_rstn <= 1'b0;
        end else begin
            out_prev <= out_bit;
            if (out_prev && !out_bit)
                drain_q <= DW'(DRAIN_CYC);
            else if (drain_q != '0)
                drain_q <= drain_q - 1'b1;
            core_byp  <= byp_bit  | (core_byp  & hold);
            core_rstn <= rstn_bit | (core_rstn & hold);
        end
    end

    // the core leaves run only after the output was off for two ticks
    assert_gate_before_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_rstn) |-> ($past(!out_bit) && $past(!out_bit, 2)))
        else $error("core reset dropped while output enabled");
endmodule

// File: rtl/pll_lock_fsm.sv
`timescale 1ns/1ps
module pll_lock_fsm
    import pll_seq_pkg::*;
#(
    parameter int SETTLE_CYC = 10,
    parameter int LOCK_CYC   = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic core_byp,
    input  logic core_rstn,
    output logic locked
);
    localparam int SW = $clog2(SETTLE_CYC + 1);
    localparam int LW = $clog2(LOCK_CYC + 1);

    lock_st_e      st_q, st_d;
    logic [SW-1:0] settle_q;
    logic [LW-1:0] cnt_q;
    logic          settle_done;
    logic          run;

    assign run         = core_byp & core_rstn;
    assign settle_done = (settle_q == SW'(SETTLE_CYC));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            settle_q <= '0;
        else if (!core_byp)
            settle_q <= '0;
        else if (!settle_done)
            settle_q <= settle_q + 1'b1;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LK_IDLE:   if (run && settle_done) st_d = LK_ACQ;
            LK_ACQ:    if (!run) st_d = LK_IDLE;
                       else if (cnt_q == LW'(LOCK_CYC - 1)) st_d = LK_LOCKED;
            LK_LOCKED: if (!run) st_d = LK_IDLE;
            default:   st_d = LK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= LK_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= (st_q == LK_ACQ) ? cnt_q + 1'b1 : '0;
        end
    end

    always_comb begin
        locked = (st_q == LK_LOCKED) && run;
    end

    assert_lock_after_settle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(settle_done))
        else $error("lock rose before settle window");
endmodule

// File: rtl/pll_vote_fsm.sv
`timescale 1ns/1ps
module pll_vote_fsm
    import pll_seq_pkg::*;
#(
    parameter int VOTE_CYC = 4,
    parameter int OFFL_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vote_en,
    input  logic vote_rst,
    input  logic off_req,
    output logic active,
    output logic off_ack
);
    localparam int VW = $clog2(VOTE_CYC + 1);
    localparam int OW = $clog2(OFFL_CYC + 1);

    vote_st_e      st_q, st_d;
    logic [VW-1:0] cnt_q;
    logic [OW-1:0] ocnt_q;

    always_comb begin
        st_d = st_q;
        if (vote_rst) st_d = VT_OFF;
        else begin
            unique case (st_q)
                VT_OFF:  if (vote_en) st_d = VT_RISE;
                VT_RISE: if (!vote_en) st_d = VT_OFF;
                         else if (cnt_q == VW'(VOTE_CYC - 1)) st_d = VT_ON;
                VT_ON:   if (!vote_en) st_d = VT_FALL;
                VT_FALL: if (vote_en) st_d = VT_ON;
                         else if (cnt_q == VW'(VOTE_CYC - 1)) st_d = VT_OFF;
                default: st_d = VT_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= VT_OFF;
            cnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_d != st_q) cnt_q <= '0;
            else if (st_q == VT_RISE || st_q == VT_FALL) cnt_q <= cnt_q + 1'b1;
            else cnt_q <= '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ocnt_q  <= '0;
            off_ack <= 1'b0;
        end else if (!off_req) begin
            ocnt_q  <= '0;
            off_ack <= 1'b0;
        end else if (!off_ack) begin
            if (ocnt_q == OW'(OFFL_CYC - 1)) off_ack <= 1'b1;
            else ocnt_q <= ocnt_q + 1'b1;
        end
    end

    always_comb begin
        active = (st_q == VT_ON) || (st_q == VT_FALL);
    end

    assert_active_follows_vote_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(vote_en))
        else $error("active rose without vote");
    assert_vote_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        vote_rst |=> !active)
        else $error("vote reset did not clear active");
    assert_offack_follows_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(off_ack) |-> $past(off_req))
        else $error("offline ack without request");
endmodule

// File: rtl/pll_update_fsm.sv
`timescale 1ns/1ps
module pll_update_fsm
    import pll_seq_pkg::*;
#(
    parameter int ACK_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic upd_bit,
    input  logic upd_byp,
    output logic ack,
    output logic commit,
    output logic auto_clr
);
    localparam int CW = $clog2(ACK_CYC + 1);

    upd_st_e       st_q, st_d;
    logic [CW-1:0] cnt_q;
    logic          wait_done;

    assign wait_done = (cnt_q == CW'(ACK_CYC - 1));

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            UP_IDLE: if (upd_bit) st_d = UP_WAIT;
            UP_WAIT: if (!upd_bit) st_d = UP_IDLE;
                     else if (wait_done) st_d = UP_ACK;
            UP_ACK:  if (!upd_bit) st_d = UP_IDLE;
            default: st_d = UP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= UP_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= (st_q == UP_WAIT) ? cnt_q + 1'b1 : '0;
        end
    end

    always_comb begin
        ack      = (st_q == UP_ACK);
        commit   = (st_q == UP_WAIT) && upd_bit && wait_done;
        auto_clr = (st_q == UP_ACK) && !upd_byp;
    end

    assert_ack_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(upd_bit, 2))
        else $error("ack too soon after update");
    assert_autoclear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !upd_byp) |=> !upd_bit)
        else $error("update bit not cleared by hardware");
    assert_ack_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack) |-> $past(!upd_bit))
        else $error("ack fell while update still set");
endmodule

// File: rtl/pll_mode_seq.sv
`timescale 1ns/1ps
module pll_mode_seq
    import pll_seq_pkg::*;
#(
    parameter int AW         = 6,
    parameter int L_W        = 16,
    parameter int ALPHA_W    = 40,
    parameter int SETTLE_CYC = 10,
    parameter int LOCK_CYC   = 20,
    parameter int ACK_CYC    = 3,
    parameter int VOTE_CYC   = 4,
    parameter int OFFL_CYC   = 3,
    parameter int DRAIN_CYC  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [AW-1:0]      bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               pll_out_en,
    output logic [L_W-1:0]     pll_l_word,
    output logic [ALPHA_W-1:0] pll_alpha_word
);
    localparam int AHI_W = ALPHA_W - 32;
    localparam int IW    = AW - 2;

    logic          m_out, m_byp, m_rstn, m_offreq, m_vote, m_vrst, m_upd, m_ubyp;
    logic [5:0]    m_lcnt, m_bcnt;
    logic [L_W-1:0]   l_q;
    logic [31:0]      alo_q, user_q, userhi_q, cfg_q, test_q, testhi_q;
    logic [AHI_W-1:0] ahi_q;

    logic          aligned, wr_ok;
    logic [IW-1:0] widx;
    logic          core_byp, core_rstn, locked, active, off_ack;
    logic          ack, commit, auto_clr;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign widx    = bus_addr[AW-1:2];
    assign wr_ok   = bus_wr && aligned;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {m_out, m_byp, m_rstn, m_offreq, m_vote, m_vrst, m_upd, m_ubyp} <= '0;
            m_lcnt <= '0; m_bcnt <= '0;
            l_q <= '0; alo_q <= '0; ahi_q <= '0;
            user_q <= '0; userhi_q <= '0; cfg_q <= '0; test_q <= '0; testhi_q <= '0;
        end else begin
            if (wr_ok) begin
                unique case (widx)
                    IW'(0): begin
                        m_out    <= bus_wdata[MB_OUT];
                        m_byp    <= bus_wdata[MB_BYP];
                        m_rstn   <= bus_wdata[MB_RSTN];
                        m_offreq <= bus_wdata[MB_OFFREQ];
                        m_lcnt   <= bus_wdata[MB_LCNT +: 6];
                        m_bcnt   <= bus_wdata[MB_BCNT +: 6];
                        m_vote   <= bus_wdata[MB_VOTE];
                        m_vrst   <= bus_wdata[MB_VRST];
                        m_ubyp   <= bus_wdata[MB_UBYP];
                    end
                    IW'(1): l_q      <= bus_wdata[L_W-1:0];
                    IW'(2): alo_q    <= bus_wdata;
                    IW'(3): ahi_q    <= bus_wdata[AHI_W-1:0];
                    IW'(4): user_q   <= bus_wdata;
                    IW'(5): userhi_q <= bus_wdata;
                    IW'(6): cfg_q    <= bus_wdata;
                    IW'(7): test_q   <= bus_wdata;
                    IW'(8): testhi_q <= bus_wdata;
                    default: ;
                endcase
            end
            // hardware clear wins over a software write in the same cycle
            if (auto_clr) m_upd <= 1'b0;
            else if (wr_ok && widx == IW'(0)) m_upd <= bus_wdata[MB_UPD];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pll_l_word     <= '0;
            pll_alpha_word <= '0;
        end else if (commit) begin
            pll_l_word     <= l_q;
            pll_alpha_word <= {ahi_q, alo_q};
        end
    end

    pll_core_gate #(.DRAIN_CYC(DRAIN_CYC)) u_gate (
        .clk(clk), .rst_n(rst_n), .out_bit(m_out), .byp_bit(m_byp), .rstn_bit(m_rstn),
        .core_byp(core_byp), .core_rstn(core_rstn)
    );

    pll_lock_fsm #(.SETTLE_CYC(SETTLE_CYC), .LOCK_CYC(LOCK_CYC)) u_lock (
        .clk(clk), .rst_n(rst_n), .core_byp(core_byp), .core_rstn(core_rstn), .locked(locked)
    );

    pll_vote_fsm #(.VOTE_CYC(VOTE_CYC), .OFFL_CYC(OFFL_CYC)) u_vote (
        .clk(clk), .rst_n(rst_n), .vote_en(m_vote), .vote_rst(m_vrst), .off_req(m_offreq),
        .active(active), .off_ack(off_ack)
    );

    pll_update_fsm #(.ACK_CYC(ACK_CYC)) u_upd (
        .clk(clk), .rst_n(rst_n), .upd_bit(m_upd), .upd_byp(m_ubyp),
        .ack(ack), .commit(commit), .auto_clr(auto_clr)
    );

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            unique case (widx)
                IW'(0): bus_rdata = {locked, active, ack, off_ack, 4'b0000,
                                     m_ubyp, m_upd, m_vrst, m_vote, m_bcnt, m_lcnt,
                                     m_offreq, 4'b0000, m_rstn, m_byp, m_out};
                IW'(1): bus_rdata = 32'(l_q);
                IW'(2): bus_rdata = alo_q;
                IW'(3): bus_rdata = 32'(ahi_q);
                IW'(4): bus_rdata = user_q;
                IW'(5): bus_rdata = userhi_q;
                IW'(6): bus_rdata = cfg_q;
                IW'(7): bus_rdata = test_q;
                IW'(8): bus_rdata = testhi_q;
                IW'(9): bus_rdata = {28'd0, locked, active, ack, off_ack};
                default: bus_rdata = '0;
            endcase
        end
        pll_out_en = m_out && locked;
    end

    assert_out_needs_lock_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_out_en) |-> m_out)
        else $error("output enabled without enable bit");
endmodule

// File: tb/sim_pll_mode_seq.sv
`timescale 1ns/100ps
module sim_pll_mode_seq;
    localparam int S = 10, L = 20, A = 3, V = 4, O = 3, D = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pll_out_en;
    logic [15:0] pll_l_word;
    logic [39:0] pll_alpha_word;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    int          q_src[$];
    logic [63:0] q_mask[$];
    logic [63:0] q_exp[$];
    string       q_tag[$];

    always #2 clk = ~clk;

    pll_mode_seq u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pll_out_en(pll_out_en),
        .pll_l_word(pll_l_word), .pll_alpha_word(pll_alpha_word)
    );

    // monitor: pops expected items and compares against the observed ports
    initial begin
        forever begin
            logic [63:0] act;
            wait (q_src.size() != 0);
            case (q_src[0])
                0: act = {32'd0, bus_rdata};
                1: act = {63'd0, pll_out_en};
                2: act = {48'd0, pll_l_word};
                default: act = {24'd0, pll_alpha_word};
            endcase
            n_chk++;
            if ((act & q_mask[0]) != (q_exp[0] & q_mask[0])) begin
                n_err++;
                $display("FAIL %s actual=%h expected=%h", q_tag[0], act & q_mask[0], q_exp[0] & q_mask[0]);
            end
            void'(q_src.pop_front()); void'(q_mask.pop_front());
            void'(q_exp.pop_front()); void'(q_tag.pop_front());
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic expect_item(int src, logic [5:0] a, logic [63:0] m, logic [63:0] e, string tag);
        bus_addr = a;
        #0.1;
        q_src.push_back(src); q_mask.push_back(m); q_exp.push_back(e); q_tag.push_back(tag);
        wait (q_src.size() == 0);
    endtask

    task automatic chk_reg(logic [5:0] a, logic [31:0] e, string tag);
        expect_item(0, a, 64'hFFFF_FFFF, {32'd0, e}, tag);
    endtask

    task automatic chk_bit(int b, logic v, string tag);
        expect_item(0, 6'h00, 64'd1 << b, {63'd0, v} << b, tag);
    endtask

    task automatic chk_port(int src, logic [63:0] e, string tag);
        expect_item(src, 6'h00, 64'hFFFF_FFFF_FFFF_FFFF, e, tag);
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_err++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk_reg(6'h00, 32'h0, "R1 mode after reset");
        chk_reg(6'h04, 32'h0, "R1 integer after reset");
        chk_reg(6'h24, 32'h0, "R1 status after reset");
        chk_port(1, 64'd0, "R1 out_en after reset");
        chk_port(2, 64'd0, "R1 l_word after reset");
        chk_port(3, 64'd0, "R1 alpha_word after reset");

        // R2 map and widths
        wr(6'h04, 32'h0001_ABCD);
        wr(6'h08, 32'hDEAD_BEEF);
        wr(6'h0C, 32'h0000_01AB);
        wr(6'h10, 32'h1234_5678);
        wr(6'h18, 32'hCAFE_0001);
        wr(6'h20, 32'h0BAD_F00D);
        wr(6'h28, 32'hFFFF_FFFF);
        wr(6'h11, 32'hFFFF_FFFF);
        chk_reg(6'h04, 32'h0000_ABCD, "R2 integer truncated");
        chk_reg(6'h08, 32'hDEAD_BEEF, "R2 fraction low");
        chk_reg(6'h0C, 32'h0000_00AB, "R2 fraction high");
        chk_reg(6'h10, 32'h1234_5678, "R2 user");
        chk_reg(6'h18, 32'hCAFE_0001, "R2 config");
        chk_reg(6'h20, 32'h0BAD_F00D, "R2 test high");
        chk_reg(6'h28, 32'h0, "R2 unmapped");
        chk_reg(6'h11, 32'h0, "R2 misaligned");
        chk_port(2, 64'd0, "R9 l_word unchanged before commit");
        chk_port(3, 64'd0, "R9 alpha_word unchanged before commit");
        wr(6'h00, 32'h000F_AB00);
        chk_reg(6'h00, 32'h000F_AB00, "R2 count fields");

        // R3 read-only and reserved bits
        wr(6'h00, 32'hFF00_0078);
        chk_reg(6'h00, 32'h0, "R3 status and reserved bits ignore writes");
        wr(6'h24, 32'hFFFF_FFFF);
        chk_reg(6'h24, 32'h0, "R3 status register ignores writes");

        // R12 enable without lock
        wr(6'h00, 32'h1);
        step(2);
        chk_port(1, 64'd0, "R12 out_en needs lock");
        wr(6'h00, 32'h0);
        step(2);

        // R4 combined release
        wr(6'h00, 32'h7);
        step(2 + S + L - 1);
        chk_bit(31, 1'b0, "R4 lock not yet");
        chk_port(1, 64'd0, "R12 out_en low before lock");
        step(1);
        chk_bit(31, 1'b1, "R4 lock at settle plus lock time");
        chk_port(1, 64'd1, "R12 out_en with lock");

        // R6 drain on combined power-down
        wr(6'h00, 32'h0);
        chk_port(1, 64'd0, "R6 output gated at once");
        chk_bit(31, 1'b1, "R6 lock held during drain");
        step(1 + D);
        chk_bit(31, 1'b1, "R6 lock still held");
        step(1);
        chk_bit(31, 1'b0, "R6 lock dropped after drain");

        // R4 ordered release
        wr(6'h00, 32'h2);
        step(40);
        chk_bit(31, 1'b0, "R4 bypass alone gives no lock");
        wr(6'h00, 32'h6);
        step(2 + L - 1);
        chk_bit(31, 1'b0, "R4 ordered lock not yet");
        step(1);
        chk_bit(31, 1'b1, "R4 ordered lock");

        // R5 reset reassert
        wr(6'h00, 32'h2);
        chk_bit(31, 1'b1, "R5 lock in write cycle");
        step(1);
        chk_bit(31, 1'b0, "R5 lock cleared");

        // R7 update with automatic clear
        wr(6'h00, 32'h0040_0002);
        step(A);
        chk_bit(29, 1'b0, "R7 ack not yet");
        chk_port(2, 64'd0, "R9 l_word before commit");
        step(1);
        chk_reg(6'h00, 32'h2040_0002, "R7 ack with update set");
        chk_port(2, 64'h0000_ABCD, "R7 l_word committed");
        chk_port(3, 64'hAB_DEAD_BEEF, "R7 alpha_word committed");
        step(1);
        chk_reg(6'h00, 32'h2000_0002, "R7 update cleared by hardware");
        step(1);
        chk_reg(6'h00, 32'h0000_0002, "R7 ack fell");

        // R9 and R8 update bypass mode
        wr(6'h04, 32'h0000_0055);
        chk_port(2, 64'h0000_ABCD, "R9 l_word kept after integer write");
        wr(6'h00, 32'h00C0_0002);
        step(A + 1);
        chk_port(2, 64'h0000_0055, "R8 commit in bypass mode");
        chk_reg(6'h00, 32'h20C0_0002, "R8 ack and update held");
        step(6);
        chk_reg(6'h00, 32'h20C0_0002, "R8 still held");
        wr(6'h00, 32'h0080_0002);
        chk_reg(6'h00, 32'h2080_0002, "R8 ack until next edge");
        step(1);
        chk_reg(6'h00, 32'h0080_0002, "R8 ack fell after software clear");
        wr(6'h00, 32'h0);
        step(4);

        // R10 vote path and R11 offline handshake
        wr(6'h00, 32'h0010_0000);
        step(V);
        chk_reg(6'h24, 32'h0, "R10 active not yet");
        step(1);
        chk_reg(6'h24, 32'h4, "R10 active raised");
        wr(6'h00, 32'h0010_0080);
        step(O - 1);
        chk_reg(6'h24, 32'h4, "R11 offline ack not yet");
        step(1);
        chk_reg(6'h24, 32'h5, "R11 offline ack raised");
        wr(6'h00, 32'h0030_0080);
        chk_reg(6'h24, 32'h5, "R10 active before vote reset edge");
        step(1);
        chk_reg(6'h24, 32'h1, "R10 vote reset cleared active");
        wr(6'h00, 32'h0010_0080);
        step(V + 1);
        chk_reg(6'h24, 32'h5, "R10 active again after reset release");
        wr(6'h00, 32'h0010_0000);
        chk_reg(6'h24, 32'h5, "R11 offline ack before clear edge");
        step(1);
        chk_reg(6'h24, 32'h4, "R11 offline ack cleared");
        wr(6'h00, 32'h0);
        step(V);
        chk_reg(6'h24, 32'h4, "R10 active held while falling");
        step(1);
        chk_reg(6'h24, 32'h0, "R10 active dropped");

        step(2);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule